// File: doc/BRIEF.md
# Memory Access Control Cell Processor

This block sits in a stream of fixed-size cells, each 14 words of 32 bits with the first word flagged by a start-of-cell strobe. It stores every cell it accepts. It then decides whether the cell is a memory command meant for this module. A command must travel on the single reserved control circuit, carry the module's own ID and carry an even opcode. Every other cell is sent on unchanged, word for word, with its original check word.

For a command, the block performs a single-word SRAM write or read through a request/grant port and then emits a response cell in place of the command. The response's opcode is the command opcode plus one. For a read, word 3 carries the data that was read. Word 1 bit 0 flags an opcode the block does not serve. The final word holds a freshly computed CRC-32. Intake is throttled with a cell-available output, so no new cell is accepted while a command is waiting for memory or a cell is being emitted.

Top module: `ctrl_cell_engine`

## Requirements
- R1: After reset, `in_avail` is 1, `out_valid` is 0 and `mem_req` is 0.
- R2: A cell whose header (word 0) does not carry VPI 0x00 in bits 27:20 and VCI 0x0023 in bits 19:4 is emitted with all 14 words unchanged and causes no memory request.
- R3: A cell on the control circuit whose module ID (word 1, bits 31:24) differs from the ID register is emitted unchanged.
- R4: The ID register resets to 0x00 and is loaded from `id_wr_data` in any cycle where `id_wr_en` is 1. Later cells are matched against the new value.
- R5: Opcode 0x02 (word 1, bits 23:16) writes word 3 to the address in word 2 (low `ADDR_W` bits), using one granted request with `mem_we`=1. The response carries opcode 0x03, bit 0 of word 1 is 0, and the other bits of words 1 to 3 are kept.
- R6: Opcode 0x04 reads the address in word 2 with `mem_we`=0. The data returned with `mem_rvalid` replaces word 3 of the response, and the opcode becomes 0x05.
- R7: Any other even opcode on a matching command makes no memory request. The response carries opcode+1 and has bit 0 of word 1 set to 1.
- R8: A matching cell with an odd opcode is not a command and is emitted unchanged.
- R9: Word 13 of every response is the CRC-32 of response words 1 to 12. The CRC uses polynomial 0x04C11DB7 with the register preset to all ones. Words are fed most significant bit first, with no reflection, and the result is inverted.
- R10: `mem_req` stays high from issue until a cycle with `mem_gnt` high, and is low in the following cycle. Each command is granted exactly once.
- R11: `in_avail` is low from the cycle after an accepted start-of-cell until the outgoing cell has been emitted, and it is low whenever `mem_req` is high. A start-of-cell seen while `in_avail` is low is ignored.
- R12: Each outgoing cell is 14 consecutive `out_valid` cycles, and `out_soc` is high only on its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_soc | input | 1 | First word of an incoming cell |
| in_data | input | 32 | Incoming cell word |
| in_avail | output | 1 | Block can take a new cell |
| out_soc | output | 1 | First word of an outgoing cell |
| out_valid | output | 1 | Outgoing word valid |
| out_data | output | 32 | Outgoing cell word |
| id_wr_en | input | 1 | Load the module ID register |
| id_wr_data | input | 8 | New module ID |
| mem_req | output | 1 | SRAM access request |
| mem_gnt | input | 1 | SRAM access grant |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The embedded properties guard the handshake and framing on every cycle. They check that the request holds until it is granted and drops right after, that intake is closed while a request is pending, and that a start-of-cell marker never appears without a valid word. Only the directed scenarios can show the content decisions: which cells count as commands, the patched opcode and error flag, the read data placed in word 3, the recomputed CRC, the effect of reloading the ID, and that a cell offered while intake is closed leaves no trace at the output.

// File: rtl/cce_pkg.sv
// Shared types and the CRC step used by the control cell processor.
// Assumes 32-bit cell words.
package cce_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_MEM,
        ST_SEND
    } eng_state_t;

    // Advance a CRC-32 register over one word, most significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [31:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 31; b >= 0; b--) begin
            fb = c[31] ^ word[b];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/cce_cell_rx.sv
// Cell capture buffer. A start pulse stores the current word as word 0.
// The following CELL_WORDS-1 words are stored on consecutive cycles.
// done pulses for one cycle once the whole cell is held.
// Assumes start is only given while idle (the top gates it).
module cce_cell_rx #(
    parameter int WORD_W     = 32,
    parameter int CELL_WORDS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] in_data,
    output logic [WORD_W-1:0] cell_q [CELL_WORDS],
    output logic              done
);
    localparam int IDX_W = $clog2(CELL_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             busy_q;

    // Word counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                idx_q  <= IDX_W'(1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // Word storage (data path, no reset needed).
    always_ff @(posedge clk) begin
        if (start && !busy_q)
            cell_q[0] <= in_data;
        else if (busy_q)
            cell_q[idx_q] <= in_data;
    end

endmodule

// File: rtl/cce_mem_port.sv
// Single-word SRAM access through request/grant.
// cmd_go latches the command and raises the request.
// The request holds until a grant is seen and drops in the next cycle.
// A write finishes at the grant. A read finishes when mem_rvalid arrives
// in any cycle after the grant. All memory outputs come from flops.
module cce_mem_port #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              done,
    output logic [WORD_W-1:0] rdata_q,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    logic wait_rd_q;

    // Request / grant / read-return sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            wait_rd_q <= 1'b0;
            done      <= 1'b0;
            rdata_q   <= '0;
        end else begin
            done <= 1'b0;
            if (cmd_go) begin
                mem_req   <= 1'b1;
                mem_we    <= cmd_we;
                mem_addr  <= cmd_addr;
                mem_wdata <= cmd_wdata;
            end else if (mem_req && mem_gnt) begin
                mem_req <= 1'b0;
                if (mem_we) done      <= 1'b1;
                else        wait_rd_q <= 1'b1;
            end else if (wait_rd_q && mem_rvalid) begin
                wait_rd_q <= 1'b0;
                rdata_q   <= mem_rdata;
                done      <= 1'b1;
            end
        end
    end

    // Request persists until granted.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req);

    // Request is withdrawn right after the grant.
    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

endmodule

// File: rtl/cce_cell_tx.sv
// Cell emitter. A start pulse sends the buffered cell as CELL_WORDS
// consecutive registered words. When patch_en is set, words 1 and 3 are
// replaced and the last word becomes the inverted CRC-32 of words 1 to
// CELL_WORDS-2 as emitted. Assumes patch inputs are stable while sending.
module cce_cell_tx
    import cce_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int CELL_WORDS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              patch_en,
    input  logic [WORD_W-1:0] word1_new,
    input  logic [WORD_W-1:0] word3_new,
    input  logic [WORD_W-1:0] cell_in [CELL_WORDS],
    output logic              out_soc,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              done
);
    localparam int IDX_W = $clog2(CELL_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

    logic [IDX_W-1:0]  idx_q;
    logic              busy_q;
    logic [31:0]       crc_q;
    logic [WORD_W-1:0] word_sel;

    // Pick the word for the current slot, patched when required.
    always_comb begin
        word_sel = cell_in[idx_q];
        if (patch_en) begin
            if (idx_q == IDX_W'(1))      word_sel = word1_new;
            else if (idx_q == IDX_W'(3)) word_sel = word3_new;
            else if (idx_q == LAST_IDX)  word_sel = ~crc_q;
        end
    end

    // Slot counter, running CRC and output flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            busy_q    <= 1'b0;
            crc_q     <= '1;
            out_soc   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy_q) begin
                out_valid <= 1'b1;
                out_soc   <= (idx_q == '0);
                out_data  <= word_sel;
                if (idx_q != '0 && idx_q != LAST_IDX)
                    crc_q <= crc32_step(crc_q, word_sel);
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end else begin
                out_valid <= 1'b0;
                out_soc   <= 1'b0;
                if (start) begin
                    busy_q <= 1'b1;
                    idx_q  <= '0;
                    crc_q  <= '1;
                end
            end
        end
    end

    // A start-of-cell marker always rides on a valid word.
    assert_soc_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    // The word after a start-of-cell marker is valid and unmarked.
    assert_soc_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |=> (out_valid && !out_soc));

endmodule

// File: rtl/ctrl_cell_engine.sv
// Control cell processor top. It captures each accepted cell and
// classifies it by header, module ID and opcode. For a command it runs a
// single SRAM access and emits a patched response; any other cell goes out
// unchanged. Intake is closed (in_avail low) from the cycle after an
// accepted start-of-cell until the outgoing cell has been sent.
// Assumes the source only starts a cell while in_avail is high.
module ctrl_cell_engine
    import cce_pkg::*;
#(
    parameter int             WORD_W     = 32,
    parameter int             CELL_WORDS = 14,
    parameter int             ADDR_W     = 18,
    parameter logic [7:0]     CTRL_VPI   = 8'h00,
    parameter logic [15:0]    CTRL_VCI   = 16'h0023,
    parameter logic [7:0]     OP_WR      = 8'h02,
    parameter logic [7:0]     OP_RD      = 8'h04,
    parameter logic [7:0]     ID_RST     = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_soc,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_avail,
    output logic              out_soc,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              id_wr_en,
    input  logic [7:0]        id_wr_data,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    eng_state_t        state_q;
    logic [7:0]        mod_id_q;
    logic              rx_start, rx_done;
    logic [WORD_W-1:0] cell_q [CELL_WORDS];
    logic              mem_go_q, mem_go_we_q, mem_done;
    logic [WORD_W-1:0] mem_rd_q;
    logic              tx_go_q, tx_done, patch_q;
    logic [WORD_W-1:0] w1_q, w3_q;
    logic              rd_cmd_q;

    logic [7:0]  hdr_vpi, cmd_id, cmd_op;
    logic [15:0] hdr_vci;
    logic        is_cmd;

    assign in_avail = (state_q == ST_IDLE);
    assign rx_start = in_soc && (state_q == ST_IDLE);

    // Field extraction and command match.
    always_comb begin
        hdr_vpi = cell_q[0][27:20];
        hdr_vci = cell_q[0][19:4];
        cmd_id  = cell_q[1][31:24];
        cmd_op  = cell_q[1][23:16];
        is_cmd  = (hdr_vpi == CTRL_VPI) && (hdr_vci == CTRL_VCI) &&
                  (cmd_id == mod_id_q) && !cmd_op[0];
    end

    // Module ID register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mod_id_q <= ID_RST;
        else if (id_wr_en) mod_id_q <= id_wr_data;
    end

    // Main sequencer: receive, optional memory access, emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mem_go_q    <= 1'b0;
            mem_go_we_q <= 1'b0;
            tx_go_q     <= 1'b0;
            patch_q     <= 1'b0;
            rd_cmd_q    <= 1'b0;
            w1_q        <= '0;
            w3_q        <= '0;
        end else begin
            mem_go_q <= 1'b0;
            tx_go_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (rx_start) state_q <= ST_RECV;
                ST_RECV: if (rx_done) begin
                    w3_q <= cell_q[3];
                    if (!is_cmd) begin
                        patch_q <= 1'b0;
                        tx_go_q <= 1'b1;
                        state_q <= ST_SEND;
                    end else begin
                        patch_q <= 1'b1;
                        if (cmd_op == OP_WR || cmd_op == OP_RD) begin
                            w1_q <= {cmd_id, cmd_op + 8'd1, cell_q[1][15:1], 1'b0};
                            mem_go_q    <= 1'b1;
                            mem_go_we_q <= (cmd_op == OP_WR);
                            rd_cmd_q    <= (cmd_op == OP_RD);
                            state_q     <= ST_MEM;
                        end else begin
                            w1_q <= {cmd_id, cmd_op + 8'd1, cell_q[1][15:1], 1'b1};
                            tx_go_q <= 1'b1;
                            state_q <= ST_SEND;
                        end
                    end
                end
                ST_MEM: if (mem_done) begin
                    if (rd_cmd_q) w3_q <= mem_rd_q;
                    tx_go_q <= 1'b1;
                    state_q <= ST_SEND;
                end
                ST_SEND: if (tx_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    cce_cell_rx #(.WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rx_start),
        .in_data (in_data),
        .cell_q  (cell_q),
        .done    (rx_done)
    );

    cce_mem_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) mem_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (mem_go_q),
        .cmd_we     (mem_go_we_q),
        .cmd_addr   (cell_q[2][ADDR_W-1:0]),
        .cmd_wdata  (cell_q[3]),
        .done       (mem_done),
        .rdata_q    (mem_rd_q),
        .mem_req    (mem_req),
        .mem_gnt    (mem_gnt),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid)
    );

    cce_cell_tx #(.WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_go_q),
        .patch_en  (patch_q),
        .word1_new (w1_q),
        .word3_new (w3_q),
        .cell_in   (cell_q),
        .out_soc   (out_soc),
        .out_valid (out_valid),
        .out_data  (out_data),
        .done      (tx_done)
    );

    // Intake is closed while a memory request is outstanding.
    assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_avail);

    // Nothing is emitted while intake is open.
    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_avail && $past(in_avail)) |-> !out_valid);

endmodule

// File: tb/ctrl_cell_engine_tb_top.sv
// Directed bench for the control cell processor.
module ctrl_cell_engine_tb_top;
    localparam int NW = 14;
    localparam logic [31:0] POLY = 32'h04C11DB7;
    typedef logic [31:0] cell_t [NW];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_soc = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_avail, out_soc, out_valid;
    logic [31:0] out_data;
    logic        id_wr_en = 1'b0;
    logic [7:0]  id_wr_data = '0;
    logic        mem_req, mem_we;
    logic        mem_gnt = 1'b0;
    logic [17:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;

    always #2 clk = ~clk;

    ctrl_cell_engine dut_i (
        .clk(clk), .rst_n(rst_n), .in_soc(in_soc), .in_data(in_data),
        .in_avail(in_avail), .out_soc(out_soc), .out_valid(out_valid),
        .out_data(out_data), .id_wr_en(id_wr_en), .id_wr_data(id_wr_data),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    cell_t stim, expc, got;
    int  cells_out = 0;
    int  widx = 0;
    int  frame_errs = 0;

    // Output monitor: assemble cells, count framing faults.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_soc) begin
                if (widx != 0) frame_errs++;
                widx = 0;
            end else if (widx == 0) begin
                frame_errs++;
            end
            if (widx < NW) got[widx] = out_data;
            widx++;
            if (widx == NW) begin
                cells_out++;
                widx = 0;
            end
        end else if (rst_n && widx != 0) begin
            frame_errs++;
            widx = 0;
        end
    end

    // SRAM model: grant after gnt_delay cycles, read data 2 cycles later.
    logic [31:0] mem [64];
    int gnt_delay = 1;
    int wait_cnt = 0;
    int grants = 0;
    int req_cycles = 0;
    int rd_count = -1;
    logic [5:0]  rd_addr;
    logic        last_we;
    logic [17:0] last_addr;
    logic [31:0] last_wdata;

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (rd_count == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[rd_addr];
        end
        if (rd_count >= 0) rd_count--;
        if (mem_gnt) begin
            mem_gnt <= 1'b0;
        end else if (rst_n && mem_req) begin
            req_cycles++;
            if (wait_cnt >= gnt_delay) begin
                mem_gnt    <= 1'b1;
                wait_cnt   = 0;
                grants++;
                last_we    = mem_we;
                last_addr  = mem_addr;
                last_wdata = mem_wdata;
                if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
                else begin
                    rd_addr  = mem_addr[5:0];
                    rd_count = 2;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic logic [31:0] ref_crc(input cell_t c);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int w = 1; w <= NW - 2; w++)
            for (int k = 0; k < 32; k++) begin
                logic top;
                top = r[31] ^ c[w][31-k];
                r = r << 1;
                if (top) r = r ^ POLY;
            end
        return ~r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic build(input logic [7:0] vpi, input logic [15:0] vci,
                         input logic [7:0] id, input logic [7:0] op,
                         input logic [31:0] addr, input logic [31:0] data);
        stim[0] = {4'h0, vpi, vci, 4'h0};
        stim[1] = {id, op, 16'h7E51};
        stim[2] = addr;
        stim[3] = data;
        for (int k = 4; k < NW - 1; k++) stim[k] = 32'h1000_0000 + k * 32'h0101;
        stim[NW-1] = ref_crc(stim);
        expc = stim;
    endtask

    task automatic patch_expect(input bit err, input logic [31:0] w3);
        expc[1] = {stim[1][31:24], stim[1][23:16] + 8'd1, stim[1][15:1], err};
        expc[3] = w3;
        expc[NW-1] = ref_crc(expc);
    endtask

    task automatic drive_cell(input bit wait_avail);
        if (wait_avail) begin
            int t = 0;
            while (!in_avail && t < 500) begin @(negedge clk); t++; end
        end
        for (int k = 0; k < NW; k++) begin
            in_soc  <= (k == 0);
            in_data <= stim[k];
            @(negedge clk);
        end
        in_soc  <= 1'b0;
        in_data <= '0;
    endtask

    task automatic wait_out(input int target, input string req);
        int t = 0;
        while (cells_out < target && t < 400) begin @(negedge clk); t++; end
        check(cells_out >= target, req, "response arrived", cells_out, target);
    endtask

    task automatic cmp_cell(input string req, input string what);
        int bad = -1;
        for (int k = NW - 1; k >= 0; k--) if (got[k] !== expc[k]) bad = k;
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, $sformatf("%s word %0d", what, bad), got[bad], expc[bad]);
    endtask

    task automatic t_reset();
        check(in_avail === 1'b1, "R1", "in_avail after reset", in_avail, 1);
        check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(mem_req === 1'b0, "R1", "mem_req after reset", mem_req, 0);
    endtask

    task automatic t_pass_plain();
        int g0 = grants, n0 = cells_out;
        build(8'h12, 16'h0023, 8'h00, 8'h02, 32'h5, 32'h1);
        drive_cell(1);
        wait_out(n0 + 1, "R2");
        cmp_cell("R2", "non-control cell unchanged");
        check(grants == g0, "R2", "no memory access", grants, g0);
        check(frame_errs == 0, "R12", "framing of passed cell", frame_errs, 0);
    endtask

    task automatic t_id_mismatch();
        int g0 = grants, n0 = cells_out;
        build(8'h00, 16'h0023, 8'h33, 8'h02, 32'h5, 32'h1);
        drive_cell(1);
        wait_out(n0 + 1, "R3");
        cmp_cell("R3", "foreign ID cell unchanged");
        check(grants == g0, "R3", "no memory access", grants, g0);
    endtask

    task automatic t_write();
        int g0 = grants, n0 = cells_out;
        build(8'h00, 16'h0023, 8'h00, 8'h02, 32'h15, 32'hCAFE_F00D);
        patch_expect(1'b0, 32'hCAFE_F00D);
        drive_cell(1);
        wait_out(n0 + 1, "R5");
        check(grants == g0 + 1, "R5", "one grant", grants, g0 + 1);
        check(last_we === 1'b1, "R5", "write strobe", last_we, 1);
        check(last_addr === 18'h15, "R5", "write address", last_addr, 32'h15);
        check(last_wdata === 32'hCAFE_F00D, "R5", "write data", last_wdata, 32'hCAFE_F00D);
        check(got[1] === expc[1], "R5", "response word 1", got[1], expc[1]);
        check(got[NW-1] === expc[NW-1], "R9", "write response CRC", got[NW-1], expc[NW-1]);
        cmp_cell("R5", "write response");
    endtask

    task automatic t_read();
        int n0 = cells_out;
        build(8'h00, 16'h0023, 8'h00, 8'h04, 32'h15, 32'h0BAD_0BAD);
        patch_expect(1'b0, 32'hCAFE_F00D);
        drive_cell(1);
        wait_out(n0 + 1, "R6");
        check(last_we === 1'b0, "R6", "read strobe", last_we, 0);
        check(got[3] === 32'hCAFE_F00D, "R6", "read data in word 3", got[3], 32'hCAFE_F00D);
        check(got[1][23:16] === 8'h05, "R6", "read response opcode", got[1][23:16], 8'h05);
        check(got[NW-1] === expc[NW-1], "R9", "read response CRC", got[NW-1], expc[NW-1]);
    endtask

    task automatic t_bad_op();
        int g0 = grants, n0 = cells_out;
        build(8'h00, 16'h0023, 8'h00, 8'h0A, 32'h15, 32'h7777_0000);
        patch_expect(1'b1, 32'h7777_0000);
        drive_cell(1);
        wait_out(n0 + 1, "R7");
        check(grants == g0, "R7", "no memory access", grants, g0);
        check(got[1] === expc[1], "R7", "opcode+1 and error flag", got[1], expc[1]);
        check(got[NW-1] === expc[NW-1], "R9", "error response CRC", got[NW-1], expc[NW-1]);
    endtask

    task automatic t_odd_op();
        int g0 = grants, n0 = cells_out;
        build(8'h00, 16'h0023, 8'h00, 8'h03, 32'h15, 32'h1);
        drive_cell(1);
        wait_out(n0 + 1, "R8");
        cmp_cell("R8", "odd opcode cell unchanged");
        check(grants == g0, "R8", "no memory access", grants, g0);
    endtask

    task automatic t_id_reload();
        int n0 = cells_out;
        id_wr_en <= 1'b1; id_wr_data <= 8'h5A;
        @(negedge clk);
        id_wr_en <= 1'b0;
        build(8'h00, 16'h0023, 8'h00, 8'h0A, 32'h0, 32'h0);
        drive_cell(1);
        wait_out(n0 + 1, "R4");
        cmp_cell("R4", "old ID no longer matches");
        build(8'h00, 16'h0023, 8'h5A, 8'h02, 32'h21, 32'h1234_5678);
        patch_expect(1'b0, 32'h1234_5678);
        drive_cell(1);
        wait_out(n0 + 2, "R4");
        cmp_cell("R4", "new ID command served");
    endtask

    task automatic t_hold_off();
        int n0 = cells_out, g0 = grants, rc0 = req_cycles;
        int t = 0;
        bit avail_seen = 0;
        gnt_delay = 20;
        build(8'h00, 16'h0023, 8'h5A, 8'h04, 32'h21, 32'h0);
        patch_expect(1'b0, 32'h1234_5678);
        drive_cell(1);
        while (!mem_req && t < 100) begin @(negedge clk); t++; end
        if (in_avail) avail_seen = 1;
        check(!avail_seen, "R11", "in_avail low while request pending", in_avail, 0);
        build(8'h44, 16'h0001, 8'h00, 8'h00, 32'h0, 32'hDEAD_BEEF);
        drive_cell(0);
        build(8'h00, 16'h0023, 8'h5A, 8'h04, 32'h21, 32'h0);
        patch_expect(1'b0, 32'h1234_5678);
        wait_out(n0 + 1, "R11");
        cmp_cell("R11", "response intact after ignored cell");
        check(grants == g0 + 1, "R10", "single grant after long wait", grants, g0 + 1);
        check(req_cycles - rc0 >= 20, "R10", "request held through wait",
              req_cycles - rc0, 20);
        repeat (60) @(negedge clk);
        check(cells_out == n0 + 1, "R11", "ignored cell not emitted", cells_out, n0 + 1);
        check(frame_errs == 0, "R12", "framing over all cells", frame_errs, 0);
        gnt_delay = 1;
    endtask

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        t_reset();
        t_pass_plain();
        t_id_mismatch();
        t_write();
        t_read();
        t_bad_op();
        t_odd_op();
        t_id_reload();
        t_hold_off();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule